// File: doc/BRIEF.md
# Tagged Receive FIFO for an Infrared Deframer

This block holds received bytes between a serial infrared deframer and the CPU or DMA engine that drains them. Each stored byte carries two status bits: an end-of-frame mark and a frame-check-failure mark. The deframer learns that a frame has ended only after its last data byte has been pushed, so it can set either mark on the most recently stored entry without writing a new one.

The read side asks for service when the fill level sits in the middle third of capacity. If the deframer pushes into a full queue, the byte is discarded, the stored entries are left untouched, and a sticky overrun flag is raised. Software clears the flag with a one-cycle pulse. Disabling the receiver empties the queue in a single cycle.

Top module: `irrx_tag_fifo`

## Requirements
- R1: After synchronous reset, the FIFO is empty, `fill_level` is 0, `fifo_full`, `svc_req` and `overrun` are low, and `rd_byte`, `rd_eof` and `rd_crc_err` are 0.
- R2: Bytes leave the FIFO in the order they were written. A read of a non-empty FIFO presents the oldest entry on `rd_byte`, `rd_eof` and `rd_crc_err` in the cycle after `rd_en` is high. These outputs hold their values when no read occurs.
- R3: `fill_level` counts the stored entries (0 to DEPTH=12). `fifo_empty` is high exactly when the count is 0, and `fifo_full` is high exactly when the count is 12. All three update in the cycle after the operation that changes them.
- R4: `svc_req` is high exactly when `fill_level` is between 4 and 8 inclusive.
- R5: A write while the FIFO holds 12 entries is discarded, even when a read occurs in the same cycle. The entries already stored are read back unchanged.
- R6: A write attempted while the FIFO is full sets `overrun`. `overrun` stays high until an `overrun_clr` pulse. If a new overrun and `overrun_clr` occur in the same cycle, the flag stays set.
- R7: `mark_eof` and `mark_crc` OR a 1 into the end-of-frame and CRC-error bits of the most recently written entry that is still stored. They are ignored when the FIFO is empty. Newly written entries start with both bits clear, and those bits appear on `rd_eof` and `rd_crc_err`.
- R8: When a mark and a write occur in the same cycle, the mark goes to the entry written before, not to the new byte.
- R9: When a mark and a read of the same entry occur in the same cycle, the read returns the entry with the mark already applied.
- R10: A read of an empty FIFO returns 0 on `rd_byte`, `rd_eof` and `rd_crc_err` and does not change the fill level.
- R11: `rx_off` empties the FIFO in one cycle. In that cycle, writes, reads and marks are ignored and the read outputs hold their values. `overrun` is not changed by `rx_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_off | input | 1 | Receiver disable; synchronous clear of the contents |
| wr_en | input | 1 | Push request from the deframer |
| wr_byte | input | 8 | Byte to push |
| mark_eof | input | 1 | Set the end-of-frame bit of the last written entry |
| mark_crc | input | 1 | Set the CRC-error bit of the last written entry |
| rd_en | input | 1 | Pop request from CPU or DMA |
| rd_byte | output | 8 | Popped byte (registered) |
| rd_eof | output | 1 | End-of-frame bit of the popped entry |
| rd_crc_err | output | 1 | CRC-error bit of the popped entry |
| fill_level | output | 4 | Number of stored entries |
| fifo_empty | output | 1 | No entries stored |
| fifo_full | output | 1 | All entries in use |
| svc_req | output | 1 | Service request, fill level within the middle band |
| overrun | output | 1 | Sticky flag for a write attempted while full |
| overrun_clr | input | 1 | Pulse that clears `overrun` |

## Verification
The bench drives four kinds of input:

- **Monotone fill past capacity, then a full drain.** This separates byte ordering, dropped bytes and the edges of the service band.
- **Frame-style bursts.** Marks come alone, together with a write, or together with a read of the only entry. These show whether a mark lands on the right entry and whether the reader sees it.
- **Clear and overrun-clear pulses.** These are placed over a full queue and collide with new overruns, which tests flag priority.
- **A long random mix of all inputs.** This exposes pointer wrap and interactions that the directed cases miss.

Every output is compared with a queue-based model on every cycle.

// File: rtl/irrx_fifo_pkg.sv
package irrx_fifo_pkg;

  // Status bits stored with every byte
  typedef struct packed {
    logic eof;
    logic crc;
  } rx_tag_t;

endpackage

// File: rtl/irrx_fifo_ptr.sv
module irrx_fifo_ptr #(
  parameter int DEPTH = 12,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic          tag_req,
  output logic          wr_fire,
  output logic          wr_drop,
  output logic          rd_fire,
  output logic          rd_zero,
  output logic          tag_fire,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [AW-1:0] last_addr,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_next
);

  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP      = CW'(DEPTH);

  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  // Occupancy is judged before this cycle's read, so a full queue drops the write
  assign wr_fire   = wr_req && !clr && (cnt != CAP);
  assign wr_drop   = wr_req && !clr && (cnt == CAP);
  assign rd_fire   = rd_req && !clr && (cnt != '0);
  assign rd_zero   = rd_req && !clr && (cnt == '0);
  assign tag_fire  = tag_req && !clr && (cnt != '0);
  assign waddr     = wp;
  assign raddr     = rp;
  assign last_addr = (wp == '0) ? LAST_IDX : wp - 1'b1;

  always_comb begin
    if (clr) cnt_next = '0;
    else     cnt_next = cnt + CW'(wr_fire) - CW'(rd_fire);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_fire) wp <= bump(wp);
      if (rd_fire) rp <= bump(rp);
      cnt <= cnt_next;
    end
  end

  // R3: the count never exceeds capacity
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst) cnt <= CAP);

  // R11: clear leaves nothing stored
  a_r11_clr_empties: assert property (@(posedge clk) disable iff (rst) clr |=> cnt == '0);

endmodule

// File: rtl/irrx_fifo_store.sv
module irrx_fifo_store
  import irrx_fifo_pkg::*;
#(
  parameter int DEPTH  = 12,
  parameter int DATA_W = 8,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tag_we,
  input  logic [AW-1:0]     tag_addr,
  input  rx_tag_t           tag_set,
  input  logic              re,
  input  logic              rz,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata,
  output rx_tag_t           rtag
);

  // Data in a plain RAM (inferable); tags in flops so they can be edited later
  logic [DATA_W-1:0] mem  [DEPTH];
  rx_tag_t           tags [DEPTH];
  rx_tag_t           fwd;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) tags[i] <= '0;
    end else begin
      if (we)     tags[waddr]    <= '0;
      if (tag_we) tags[tag_addr] <= tags[tag_addr] | tag_set;
    end
  end

  // A mark aimed at the entry being read is merged into the read result
  assign fwd = (tag_we && tag_addr == raddr) ? tag_set : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      rtag  <= '0;
    end else if (re) begin
      rdata <= mem[raddr];
      rtag  <= tags[raddr] | fwd;
    end else if (rz) begin
      rdata <= '0;
      rtag  <= '0;
    end
  end

  // R10: an empty read yields zeros
  a_r10_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    rz |=> (rdata == '0) && (rtag == '0));

endmodule

// File: rtl/irrx_tag_fifo.sv
module irrx_tag_fifo
  import irrx_fifo_pkg::*;
#(
  parameter int DEPTH  = 12,
  parameter int DATA_W = 8,
  parameter int REQ_LO = DEPTH / 3,
  parameter int REQ_HI = (2 * DEPTH) / 3,
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_off,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              mark_eof,
  input  logic              mark_crc,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_byte,
  output logic              rd_eof,
  output logic              rd_crc_err,
  output logic [CW-1:0]     fill_level,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic              svc_req,
  output logic              overrun,
  input  logic              overrun_clr
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [CW-1:0] LO  = CW'(REQ_LO);
  localparam logic [CW-1:0] HI  = CW'(REQ_HI);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic          wr_fire, wr_drop, rd_fire, rd_zero, tag_fire;
  logic [AW-1:0] waddr, raddr, last_addr;
  logic [CW-1:0] cnt_next;
  rx_tag_t       tag_set, rtag;

  assign tag_set = '{eof: mark_eof, crc: mark_crc};

  irrx_fifo_ptr #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .clr      (rx_off),
    .wr_req   (wr_en),
    .rd_req   (rd_en),
    .tag_req  (mark_eof | mark_crc),
    .wr_fire  (wr_fire),
    .wr_drop  (wr_drop),
    .rd_fire  (rd_fire),
    .rd_zero  (rd_zero),
    .tag_fire (tag_fire),
    .waddr    (waddr),
    .raddr    (raddr),
    .last_addr(last_addr),
    .cnt      (fill_level),
    .cnt_next (cnt_next)
  );

  irrx_fifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_fire),
    .waddr   (waddr),
    .wdata   (wr_byte),
    .tag_we  (tag_fire),
    .tag_addr(last_addr),
    .tag_set (tag_set),
    .re      (rd_fire),
    .rz      (rd_zero),
    .raddr   (raddr),
    .rdata   (rd_byte),
    .rtag    (rtag)
  );

  assign rd_eof     = rtag.eof;
  assign rd_crc_err = rtag.crc;

  // Flags registered from the next count so they line up with fill_level
  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_empty <= 1'b1;
      fifo_full  <= 1'b0;
      svc_req    <= 1'b0;
    end else begin
      fifo_empty <= (cnt_next == '0);
      fifo_full  <= (cnt_next == CAP);
      svc_req    <= (cnt_next >= LO) && (cnt_next <= HI);
    end
  end

  // Sticky overrun; a new event outranks the clear pulse
  always_ff @(posedge clk) begin
    if (rst)              overrun <= 1'b0;
    else if (wr_drop)     overrun <= 1'b1;
    else if (overrun_clr) overrun <= 1'b0;
  end

  // R4: the request follows the band of the count
  a_r4_req_band: assert property (@(posedge clk) disable iff (rst)
    svc_req == ((fill_level >= LO) && (fill_level <= HI)));

  // R5: a write into a full queue leaves the level unchanged
  a_r5_full_keeps: assert property (@(posedge clk) disable iff (rst)
    fifo_full && wr_en && !rd_en && !rx_off |=> fifo_full && $stable(fill_level));

  // R6: a write attempted while full sets overrun
  a_r6_overrun_set: assert property (@(posedge clk) disable iff (rst)
    fifo_full && wr_en && !rx_off |=> overrun);

  // R6: overrun stays set without a clear pulse
  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun && !overrun_clr |=> overrun);

  // R3: the flags agree with the count
  a_r3_flags: assert property (@(posedge clk) disable iff (rst)
    (fifo_empty == (fill_level == '0)) && (fifo_full == (fill_level == CAP)));

endmodule

// File: tb/irrx_tag_fifo_tb_top.sv
module irrx_tag_fifo_tb_top;

  localparam int DEPTH = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_off = 0, wr_en = 0, mark_eof = 0, mark_crc = 0, rd_en = 0, overrun_clr = 0;
  logic [7:0] wr_byte = '0;
  logic [7:0] rd_byte;
  logic       rd_eof, rd_crc_err, fifo_empty, fifo_full, svc_req, overrun;
  logic [3:0] fill_level;

  always #10 clk = ~clk;

  irrx_tag_fifo dut_i (
    .clk(clk), .rst(rst), .rx_off(rx_off), .wr_en(wr_en), .wr_byte(wr_byte),
    .mark_eof(mark_eof), .mark_crc(mark_crc), .rd_en(rd_en),
    .rd_byte(rd_byte), .rd_eof(rd_eof), .rd_crc_err(rd_crc_err),
    .fill_level(fill_level), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .svc_req(svc_req), .overrun(overrun), .overrun_clr(overrun_clr)
  );

  // Reference model: entry = {eof, crc, byte}
  logic [9:0] q[$];
  logic [9:0] m_out = '0;
  bit         m_ovr = 0;
  int         errors = 0, checks = 0;
  string      focus = "R1";
  bit         done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s/%s actual=%0h expected=%0h at %0t", req, focus, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R3 level", fill_level, q.size());
    chk("R3 empty", fifo_empty, q.size() == 0);
    chk("R3 full", fifo_full, q.size() == DEPTH);
    chk("R4 svc_req", svc_req, (q.size() >= 4) && (q.size() <= 8));
    chk("R6 overrun", overrun, m_ovr);
    chk("R2 byte", rd_byte, m_out[7:0]);
    chk("R7 eof", rd_eof, m_out[9]);
    chk("R7 crc", rd_crc_err, m_out[8]);
  endtask

  task automatic model(input bit w, input logic [7:0] d, input bit te, input bit tc,
                       input bit r, input bit c, input bit oc);
    bit full_pre, empty_pre, drop;
    drop = 0;
    if (c) begin
      q.delete();                                   // R11
    end else begin
      if ((te || tc) && q.size() > 0) q[$] = q[$] | {te, tc, 8'h00};  // R7, R8
      full_pre  = (q.size() == DEPTH);
      empty_pre = (q.size() == 0);
      if (r) begin
        if (empty_pre) m_out = '0;                  // R10
        else m_out = q.pop_front();                 // R2, R9
      end
      if (w) begin
        if (full_pre) drop = 1;                     // R5
        else q.push_back({2'b00, d});
      end
    end
    if (drop) m_ovr = 1;                            // R6
    else if (oc) m_ovr = 0;
  endtask

  task automatic step(input bit w, input logic [7:0] d, input bit te, input bit tc,
                      input bit r, input bit c, input bit oc);
    wr_en = w; wr_byte = d; mark_eof = te; mark_crc = tc;
    rd_en = r; rx_off = c; overrun_clr = oc;
    @(posedge clk);
    #1;
    model(w, d, te, tc, r, c, oc);
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    focus = "R1";
    compare();
    chk("R1 empty after reset", fifo_empty, 1);

    // Fill beyond capacity: R3, R4, R5, R6
    focus = "R5";
    for (int i = 0; i < DEPTH + 3; i++) step(1, 8'(8'h30 + i), 0, 0, 0, 0, 0);
    chk("R6 overrun raised", overrun, 1);
    step(1, 8'hEE, 0, 0, 1, 0, 1);                  // full+read: still dropped, overrun beats clear
    chk("R6 set beats clear", overrun, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R6 cleared", overrun, 0);

    // Drain and read empty: R2, R10
    focus = "R2";
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 0, 1, 0, 0);
    focus = "R10";
    chk("R10 empty read zero", rd_byte, 0);

    // Marks: R7, R8, R9
    focus = "R7";
    step(0, 0, 1, 1, 0, 0, 0);                      // ignored while empty
    step(1, 8'hA1, 0, 0, 0, 0, 0);
    step(1, 8'hA2, 1, 0, 0, 0, 0);                  // R8: mark goes to A1
    step(0, 0, 0, 1, 0, 0, 0);                      // crc on A2
    focus = "R8";
    step(0, 0, 0, 0, 1, 0, 0);
    chk("R8 mark on previous", rd_eof, 1);
    focus = "R9";
    step(0, 0, 1, 0, 1, 0, 0);                      // read A2 while marking it
    chk("R9 read sees mark", rd_eof, 1);
    chk("R9 crc kept", rd_crc_err, 1);

    // Clear: R11
    focus = "R11";
    for (int i = 0; i < 6; i++) step(1, 8'(i), 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) step(1, 8'(i), 0, 0, 0, 0, 0);
    step(1, 8'h55, 1, 1, 1, 1, 0);
    chk("R11 cleared", fill_level, 0);
    chk("R11 overrun untouched", overrun, 1);
    step(0, 0, 0, 0, 0, 0, 1);

    // Random mix
    focus = "random";
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 99) < 55, 8'($urandom), $urandom_range(0, 9) == 0,
           $urandom_range(0, 9) == 0, $urandom_range(0, 99) < 45,
           $urandom_range(0, 199) == 0, $urandom_range(0, 19) == 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule